// File: doc/BRIEF.md
# Serial Port Control Register Block

This block is the word-addressed control and status front end of a simple serial port. A host issues 32-bit reads and writes on a plain register bus. Bytes written to the transmit-data register are queued in a byte-wide FIFO. A stub drain handshake hands them, oldest first, to a bit serializer that lives outside the block. A single receive-data register captures bytes that arrive from the receive side. The block also forwards a 16-bit baud value from the control register to the transmitter.

Four interrupt sources live in a state register. Each source is set by a hardware event or by the test register, and cleared by writing ones to the state register. An enable register masks the sources onto four level-sensitive outputs. The transmit watermark source tracks the FIFO level against a programmable threshold: a push that reaches the threshold sets it, and a drain that takes the level below it clears it.

The register map is given by word index on `bus_addr`:

| Index | Register |
|---|---|
| 0 | interrupt state |
| 1 | interrupt enable |
| 2 | interrupt test |
| 3 | control |
| 4 | status |
| 5 | receive data |
| 6 | transmit data |
| 7 | FIFO control |
| 8 | FIFO status |

Interrupt bit mapping, used by the state, enable and test registers: bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty, bit 3 is receive overflow.

Top module: `serial_csr_block`

## Requirements
- R1: Each interrupt output (`irq_tx_wm`=bit 0, `irq_rx_wm`=bit 1, `irq_tx_empty`=bit 2, `irq_rx_ovf`=bit 3) is high exactly while that bit is set in both the interrupt state register (index 0) and the interrupt enable register (index 1).
- R2: A write to index 0 clears every state bit written as one and leaves bits written as zero unchanged.
- R3: A write to index 2 sets the state bits written as one. A read of index 2 returns zero.
- R4: After reset the status register (index 4) reads 0x0000003C and every other register reads zero. Status bits are: 0 transmit full, 1 receive full, 2 transmit empty, 3 transmit idle, 4 receive idle, 5 receive empty.
- R5: Each write to index 6 pushes `bus_wdata[7:0]` into a FIFO of `TX_DEPTH` entries, and bytes leave in write order. A write made while the FIFO is full is dropped.
- R6: Transmit full is set exactly while the level equals `TX_DEPTH`. Transmit empty and transmit idle are set exactly while the level is zero.
- R7: The transmit-watermark state bit sets when an accepted push leaves the level at or above the threshold held in FIFO control bits [13:8]. It clears when a drain leaves the level below that threshold.
- R8: A drain that brings the level to zero sets the transmit-empty state bit.
- R9: FIFO status (index 8) returns the transmit level in its low bits. Writing FIFO control with bit 1 set empties the FIFO.
- R10: Control (index 3) bit 0 enables transmission. `drain_valid` is low while it is clear. Control bits [31:16] appear on `baud_nco`.
- R11: While control bit 1 is set, an `rx_valid` pulse loads `rx_data` into the receive-data register (index 5) and clears receive empty and receive idle. A byte arriving while the register is still unread sets the receive-overflow state bit. Reading index 5 returns the byte and sets receive empty and receive idle again. While control bit 1 is clear, `rx_valid` has no effect.
- R12: Writes to status, receive data and FIFO status have no effect.
- R13: When a hardware set and a software clear hit the same state bit in one cycle, the bit ends up set.
- R14: Read data appears on `bus_rdata` in the cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_en | input | 1 | access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| rx_valid | input | 1 | received byte strobe |
| rx_data | input | 8 | received byte |
| drain_valid | output | 1 | a byte is offered to the serializer |
| drain_ready | input | 1 | serializer takes the offered byte |
| drain_data | output | 8 | oldest queued byte |
| baud_nco | output | 16 | baud increment for the transmitter |
| irq_tx_wm | output | 1 | transmit watermark interrupt |
| irq_rx_wm | output | 1 | receive watermark interrupt |
| irq_tx_empty | output | 1 | transmit empty interrupt |
| irq_rx_ovf | output | 1 | receive overflow interrupt |

## Verification
Every register update, FIFO push or pop and interrupt state change takes effect on the clock edge that samples the access. Interrupt outputs, `drain_valid`, `drain_data` and `baud_nco` can therefore be checked on the falling edge just after that edge. Read data is registered once, so the bench queues an expected word when it issues a read, and a monitor compares it on the falling edge after the sampling edge. All stimulus changes on falling edges. This keeps every comparison one half period clear of the edge that produced the value, and lets the same-cycle set-versus-clear case be driven in exactly one cycle.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

    localparam int WORD_W = 32;
    localparam int IRQ_N  = 4;

    typedef enum logic [3:0] {
        A_INT_STATE = 4'd0,
        A_INT_EN    = 4'd1,
        A_INT_TEST  = 4'd2,
        A_CTRL      = 4'd3,
        A_STATUS    = 4'd4,
        A_RX_DATA   = 4'd5,
        A_TX_DATA   = 4'd6,
        A_FIFO_CTRL = 4'd7,
        A_FIFO_STAT = 4'd8
    } reg_addr_e;

    localparam int IRQ_TX_WM    = 0;
    localparam int IRQ_RX_WM    = 1;
    localparam int IRQ_TX_EMPTY = 2;
    localparam int IRQ_RX_OVF   = 3;

    localparam int THR_LSB     = 8;
    localparam int CLR_TX_BIT  = 1;

    typedef struct packed {
        logic [15:0] baud;
        logic [13:0] unused;
        logic        rx_en;
        logic        tx_en;
    } ctrl_t;

    typedef struct packed {
        logic rx_empty;
        logic rx_idle;
        logic tx_idle;
        logic tx_empty;
        logic rx_full;
        logic tx_full;
    } status_t;

    function automatic logic [IRQ_N-1:0] next_irq_state(
        input logic [IRQ_N-1:0] cur,
        input logic [IRQ_N-1:0] sw_clr,
        input logic [IRQ_N-1:0] hw_clr,
        input logic [IRQ_N-1:0] hw_set,
        input logic [IRQ_N-1:0] test_set
    );
        return (cur & ~sw_clr & ~hw_clr) | hw_set | test_set;
    endfunction

endpackage

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       wdata,
    output logic             accepted,
    input  logic             pop,
    output logic [7:0]       rdata,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign accepted = push && !clr && (level != FULL_LVL);
    assign do_pop   = pop && !clr && (level != '0);
    assign rdata    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accepted) wr_ptr <= bump(wr_ptr);
            if (do_pop)   rd_ptr <= bump(rd_ptr);
            level <= level + LVL_W'(accepted) - LVL_W'(do_pop);
        end
    end

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !clr && level == FULL_LVL) |=> (level == FULL_LVL));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0));
    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);
endmodule

// File: rtl/serial_irq_bank.sv
module serial_irq_bank
    import serial_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] sw_clr,
    input  logic [IRQ_N-1:0] hw_clr,
    input  logic [IRQ_N-1:0] hw_set,
    input  logic [IRQ_N-1:0] test_set,
    input  logic [IRQ_N-1:0] enable,
    output logic [IRQ_N-1:0] state,
    output logic [IRQ_N-1:0] irq
);
    logic [IRQ_N-1:0] state_nx;
    assign state_nx = next_irq_state(state, sw_clr, hw_clr, hw_set, test_set);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) state[i] <= 1'b0;
            else     state[i] <= state_nx[i];
        end
        assign irq[i] = state[i] & enable[i];

        // R13
        hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            hw_set[i] |=> state[i]);
        // R2
        w1c_chk: assert property (@(posedge clk) disable iff (rst)
            (sw_clr[i] && !hw_set[i] && !test_set[i]) |=> !state[i]);
        // R3
        test_sets_chk: assert property (@(posedge clk) disable iff (rst)
            test_set[i] |=> state[i]);
    end
endmodule

// File: rtl/serial_csr_block.sv
module serial_csr_block
    import serial_csr_pkg::*;
#(
    parameter int TX_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        drain_valid,
    input  logic        drain_ready,
    output logic [7:0]  drain_data,
    output logic [15:0] baud_nco,
    output logic        irq_tx_wm,
    output logic        irq_rx_wm,
    output logic        irq_tx_empty,
    output logic        irq_rx_ovf
);
    localparam int LVL_W = $clog2(TX_DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(TX_DEPTH);

    ctrl_t            ctrl_q;
    logic [IRQ_N-1:0] int_en_q, irq_state, irq_vec;
    logic [LVL_W-1:0] thr_q, level;
    logic [7:0]       rx_q;
    logic             rx_full_q;
    status_t          stat;

    logic wr, rd, push_req, push_ok, pop, tx_clr, rx_take, rx_read;
    logic [LVL_W:0]   level_nx;
    logic [IRQ_N-1:0] sw_clr, hw_clr, hw_set, test_set;

    assign wr       = bus_en && bus_we;
    assign rd       = bus_en && !bus_we;
    assign push_req = wr && bus_addr == A_TX_DATA;
    assign tx_clr   = wr && bus_addr == A_FIFO_CTRL && bus_wdata[CLR_TX_BIT];
    assign pop      = drain_valid && drain_ready && !tx_clr;
    assign rx_take  = rx_valid && ctrl_q.rx_en;
    assign rx_read  = rd && bus_addr == A_RX_DATA;

    serial_tx_queue #(.DEPTH(TX_DEPTH), .LVL_W(LVL_W)) u_queue (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(push_req), .wdata(bus_wdata[7:0]), .accepted(push_ok),
        .pop(pop), .rdata(drain_data), .level(level)
    );

    assign drain_valid = ctrl_q.tx_en && (level != '0);
    assign baud_nco    = ctrl_q.baud;

    // level after this cycle's push and pop, used for watermark and empty events
    always_comb begin
        level_nx = {1'b0, level} + (LVL_W + 1)'(push_ok) - (LVL_W + 1)'(pop);
        hw_set = '0;
        hw_clr = '0;
        hw_set[IRQ_TX_WM]    = push_ok && (level_nx >= {1'b0, thr_q});
        hw_clr[IRQ_TX_WM]    = !push_ok && pop && (level_nx < {1'b0, thr_q});
        hw_set[IRQ_TX_EMPTY] = pop && (level_nx == '0);
        hw_set[IRQ_RX_OVF]   = rx_take && rx_full_q && !rx_read;
        sw_clr   = (wr && bus_addr == A_INT_STATE) ? bus_wdata[IRQ_N-1:0] : '0;
        test_set = (wr && bus_addr == A_INT_TEST)  ? bus_wdata[IRQ_N-1:0] : '0;
    end

    serial_irq_bank u_irq (
        .clk(clk), .rst(rst), .sw_clr(sw_clr), .hw_clr(hw_clr),
        .hw_set(hw_set), .test_set(test_set), .enable(int_en_q),
        .state(irq_state), .irq(irq_vec)
    );

    assign irq_tx_wm    = irq_vec[IRQ_TX_WM];
    assign irq_rx_wm    = irq_vec[IRQ_RX_WM];
    assign irq_tx_empty = irq_vec[IRQ_TX_EMPTY];
    assign irq_rx_ovf   = irq_vec[IRQ_RX_OVF];

    always_comb begin
        stat.tx_full  = (level == FULL_LVL);
        stat.rx_full  = rx_full_q;
        stat.tx_empty = (level == '0);
        stat.tx_idle  = (level == '0);
        stat.rx_idle  = !rx_full_q;
        stat.rx_empty = !rx_full_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            int_en_q <= '0;
            thr_q    <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_CTRL:      ctrl_q   <= ctrl_t'(bus_wdata);
                A_INT_EN:    int_en_q <= bus_wdata[IRQ_N-1:0];
                A_FIFO_CTRL: thr_q    <= bus_wdata[THR_LSB +: LVL_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q      <= '0;
            rx_full_q <= 1'b0;
        end else if (rx_take) begin
            rx_q      <= rx_data;
            rx_full_q <= 1'b1;
        end else if (rx_read) begin
            rx_full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd) begin
            case (bus_addr)
                A_INT_STATE: bus_rdata <= WORD_W'(irq_state);
                A_INT_EN:    bus_rdata <= WORD_W'(int_en_q);
                A_CTRL:      bus_rdata <= ctrl_q;
                A_STATUS:    bus_rdata <= WORD_W'(stat);
                A_RX_DATA:   bus_rdata <= WORD_W'(rx_q);
                A_FIFO_CTRL: bus_rdata <= WORD_W'(thr_q) << THR_LSB;
                A_FIFO_STAT: bus_rdata <= WORD_W'(level);
                default:     bus_rdata <= '0;
            endcase
        end
    end

    // R7
    wm_set_chk: assert property (@(posedge clk) disable iff (rst)
        (push_ok && level_nx >= {1'b0, thr_q}) |=> irq_state[IRQ_TX_WM]);
    // R8
    empty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push_ok && level == LVL_W'(1)) |=> irq_state[IRQ_TX_EMPTY]);
    // R10
    no_drain_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.tx_en && !push_ok && !tx_clr) |=> (level == $past(level)));
    // R11
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ctrl_q.rx_en) |=> $stable(rx_q));
endmodule

// File: tb/test_serial_csr_block.sv
module test_serial_csr_block;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        drain_valid, drain_ready = 1'b0;
    logic [7:0]  drain_data;
    logic [15:0] baud_nco;
    logic        irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;

    int n_checks = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #5 clk = ~clk;

    serial_csr_block i_serial_csr_block (.*);

    always @(posedge clk) rd_q <= bus_en && !bus_we;

    // monitor: compare registered read data against the queued expectation
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        n_checks++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", t, act, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pop_one();
        drain_ready = 1'b1;
        @(negedge clk);
        drain_ready = 1'b0;
    endtask

    task automatic rx_pulse(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(4, 32'h3C, "R4 status reset");
        rd(0, 0, "R4 int state reset");
        rd(3, 0, "R4 ctrl reset");
        rd(8, 0, "R4 fifo status reset");
        chk("R4 irq reset", {irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf}, 0);

        wr(3, 32'h1234_0000);
        chk("R10 baud", baud_nco, 32'h1234);
        wr(7, 4 << 8);
        rd(7, 32'h400, "R7 threshold readback");
        wr(1, 32'hF);

        for (int i = 0; i < 3; i++) wr(6, 32'hA0 + i);
        rd(8, 3, "R9 level 3");
        chk("R7 wm below thr", irq_tx_wm, 0);
        rd(4, 32'h30, "R6 empty cleared R14");
        wr(6, 32'hA3);
        chk("R7 R1 wm at thr", irq_tx_wm, 1);
        rd(0, 1, "R7 state");

        pop_one();
        chk("R10 no drain when off", drain_valid, 0);
        rd(8, 4, "R10 level kept");

        wr(3, 32'h1234_0001);
        chk("R10 drain valid", drain_valid, 1);
        chk("R5 head A0", drain_data, 32'hA0);
        pop_one();
        rd(0, 0, "R7 wm cleared below thr");
        for (int i = 1; i < 4; i++) begin
            chk("R5 order", drain_data, 32'hA0 + i);
            pop_one();
        end
        rd(0, 4, "R8 empty state");
        chk("R8 R1 irq empty", irq_tx_empty, 1);
        rd(4, 32'h3C, "R6 empty again");

        wr(2, 32'hA);
        rd(0, 32'hE, "R3 test sets");
        chk("R3 R1 irq ovf", irq_rx_ovf, 1);
        rd(2, 0, "R3 test reads zero");
        wr(0, 32'h2);
        rd(0, 32'hC, "R2 w1c one bit");
        wr(1, 0);
        chk("R1 masked", {irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf}, 0);
        wr(0, 32'hF);
        rd(0, 0, "R2 clear all");

        // R13: pop to zero while software clears the same bit
        wr(1, 32'hF);
        wr(7, 0);
        wr(6, 32'hB0);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 0; bus_wdata = 32'h4;
        drain_ready = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; drain_ready = 1'b0;
        rd(0, 32'h5, "R13 hw set wins");

        wr(3, 32'h1234_0000);
        for (int i = 0; i < 33; i++) wr(6, i);
        rd(8, 32, "R5 full drop");
        rd(4, 32'h31, "R6 full set");
        wr(3, 32'h1234_0001);
        chk("R5 first kept", drain_data, 0);
        pop_one();
        rd(4, 32'h30, "R6 full cleared");
        rd(8, 31, "R9 level 31");
        wr(7, 32'h2);
        rd(8, 0, "R9 clear");
        chk("R9 nothing offered", drain_valid, 0);

        wr(4, 0);
        rd(4, 32'h3C, "R12 status write ignored");
        wr(8, 32'hFF);
        rd(8, 0, "R12 fifo status write ignored");
        wr(5, 32'h77);
        rd(5, 0, "R12 rx data write ignored");

        rx_pulse(8'h55);
        rd(4, 32'h3C, "R11 rx disabled");
        wr(3, 32'h2);
        rx_pulse(8'h5A);
        rd(4, 32'h0E, "R11 rx full");
        rd(5, 32'h5A, "R11 rx byte");
        rd(4, 32'h3C, "R11 rx read sets empty");
        wr(0, 32'hF);
        rx_pulse(8'h11);
        rx_pulse(8'h22);
        rd(0, 32'h8, "R11 overflow");
        rd(5, 32'h22, "R11 latest byte");
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule